// File: doc/BRIEF.md
# Remote Byte Ring Client

This block lets a local user produce bytes into, and consume bytes from, circular byte buffers that live in the memory of another processor. Every access to that memory goes through a shared bus: the block raises a bus request, waits for the grant, issues single-byte reads and writes, then drops the request and waits for the grant to fall. Each ring is identified by a base address. Three header bytes sit just below the base: the index mask (ring size minus one), the producer index and the consumer index. The payload starts at the base.

The user sends one request at a time over a valid/ready handshake: initialise a ring, ask whether it is empty, ask whether it is full, take one byte, or put one byte. The block keeps a local descriptor for each ring, holding the base, the mask, and the index it owns for each direction. It answers every accepted request with a one-cycle response pulse that carries a data byte, a status flag and an error flag. Take and put first check the ring state in one bus ownership. They repeat that check, releasing the bus each time, until the ring allows the transfer. They then move the byte and update the remote index in a second ownership.

Top module: `mem_ring_client`

## Requirements
- R1: After reset `reqReady` is 1 and `busReq`, `memValid` and `rspValid` are 0. Every ring descriptor starts with base 0 (unconfigured).
- R2: For a ring with base B, addresses are computed modulo 2^ADDR_W. The mask byte is at B-3, the producer index at B-2 and the consumer index at B-1. Payload byte i is at B+i.
- R3: Init (`reqOp`=0) stores `reqBase` as the ring's base. It then reads the mask, the producer index and the consumer index into the descriptor, all three within one bus ownership.
- R4: Empty query (`reqOp`=1) reads the remote producer index. It answers `rspFlag`=1 exactly when that index equals the locally held consumer index.
- R5: Full query (`reqOp`=2) reads the remote consumer index. It answers `rspFlag`=1 exactly when (local producer index + 1) AND mask equals that index.
- R6: On a ring whose base is 0, empty and full queries answer `rspFlag`=1 without requesting the bus. Get and put answer `rspErr`=1 without requesting the bus.
- R7: Get (`reqOp`=3) polls the remote producer index until the ring is not empty. It then reads the byte at base + consumer index and returns it on `rspByte`. It sets the consumer index to (index+1) AND mask and writes the new value to B-1.
- R8: Put (`reqOp`=4) polls the remote consumer index until the ring is not full. It then writes `reqByte` at base + producer index. It sets the producer index to (index+1) AND mask and writes the new value to B-2.
- R9: Each status poll is one bus ownership, and the data transfer with its index write-back is a separate one. The bus request is dropped and the grant is seen low between them, so a get or put that is not blocked takes exactly two ownerships.
- R10: A request whose ring number is NUM_RINGS or above, or whose operation code is above 4, answers `rspErr`=1 without requesting the bus.
- R11: `memValid` is high only while both `busReq` and `busGnt` are high. Once raised, it stays high with `memAddr`, `memWe` and `memWdata` unchanged until `memReady` is seen.
- R12: Each accepted request gets exactly one `rspValid` pulse, one cycle long. `reqReady` is 0 from the cycle after acceptance until the response has been given.
- R13: Operations on one ring leave every other ring's descriptor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | User request valid |
| reqReady | output | 1 | Block can accept a request |
| reqOp | input | 3 | 0 init, 1 empty query, 2 full query, 3 get, 4 put |
| reqRing | input | RING_ID_W | Ring number |
| reqBase | input | ADDR_W | Base address (init only) |
| reqByte | input | IDX_W | Byte to put |
| rspValid | output | 1 | One-cycle response pulse |
| rspByte | output | IDX_W | Byte returned by get |
| rspFlag | output | 1 | Result of empty or full query |
| rspErr | output | 1 | Request rejected |
| busReq | output | 1 | Bus ownership request |
| busGnt | input | 1 | Bus ownership grant |
| memValid | output | 1 | Memory access valid |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Remote byte address |
| memWdata | output | IDX_W | Write data |
| memReady | input | 1 | Access complete; read data valid |
| memRdata | input | IDX_W | Read data |

## Verification
The assertions check on every cycle that memory accesses happen only under a granted bus and stay stable until completed, that the response is a single-cycle pulse, that the block goes busy after accepting a request, and that rejected requests end without holding the bus. Only the bench scenarios can show the header and payload addressing with base-relative wrap-around, the index arithmetic under the mask, polling that stays blocked until the peer moves an index, the two-ownership split, and the independence of rings. The bench does this by running a peer memory model and comparing each byte and header against an index model it keeps itself.

// File: rtl/mem_ring_pkg.sv
package mem_ring_pkg;

  typedef enum logic [2:0] {
    OP_INIT  = 3'd0,
    OP_EMPTY = 3'd1,
    OP_FULL  = 3'd2,
    OP_GET   = 3'd3,
    OP_PUT   = 3'd4
  } ringOp_e;

  typedef enum logic [2:0] {
    AS_MASK  = 3'd0,
    AS_PROD  = 3'd1,
    AS_CONS  = 3'd2,
    AS_PDATA = 3'd3,
    AS_CDATA = 3'd4
  } addrSel_e;

  typedef enum logic [1:0] {
    WS_DATA = 2'd0,
    WS_PIDX = 2'd1,
    WS_CIDX = 2'd2
  } wdSel_e;

  typedef struct packed {
    logic     latchReq;
    logic     setBase;
    logic     ldMask;
    logic     ldProd;
    logic     ldCons;
    logic     capRemote;
    logic     capData;
    logic     advProd;
    logic     advCons;
    addrSel_e addrSel;
    wdSel_e   wdSel;
  } dpStrobe_t;

endpackage

// File: rtl/mem_ring_dpath.sv
module mem_ring_dpath
  import mem_ring_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int RING_ID_W = 3,
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [RING_ID_W-1:0] reqRing,
  input  logic [ADDR_W-1:0]    reqBase,
  input  logic [IDX_W-1:0]     reqByte,
  input  logic [IDX_W-1:0]     memRdata,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [IDX_W-1:0]     memWdata,
  output logic                 ringBad,
  output logic                 ringUnconf,
  output logic                 remEmpty,
  output logic                 remFull,
  output logic [IDX_W-1:0]     rdByte
);

  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_PROD = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_CONS = ADDR_W'(1);

  logic [RING_ID_W-1:0] curRingQ;
  logic [ADDR_W-1:0]    curBaseQ;
  logic [IDX_W-1:0]     curByteQ;
  logic [IDX_W-1:0]     remoteQ;
  logic [IDX_W-1:0]     rdByteQ;

  logic [ADDR_W-1:0] baseArr [NUM_RINGS];
  logic [IDX_W-1:0]  maskArr [NUM_RINGS];
  logic [IDX_W-1:0]  prodArr [NUM_RINGS];
  logic [IDX_W-1:0]  consArr [NUM_RINGS];

  logic [ADDR_W-1:0] selBase;
  logic [IDX_W-1:0]  selMask, selProd, selCons;
  logic [IDX_W-1:0]  prodNext, consNext;

  // Request capture and transfer holding registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curRingQ <= '0;
      curBaseQ <= '0;
      curByteQ <= '0;
      remoteQ  <= '0;
      rdByteQ  <= '0;
    end else begin
      if (strb.latchReq) begin
        curRingQ <= reqRing;
        curBaseQ <= reqBase;
        curByteQ <= reqByte;
      end
      if (strb.capRemote) remoteQ <= memRdata;
      if (strb.capData)   rdByteQ <= memRdata;
    end
  end

  // One descriptor per ring; only the addressed one is touched
  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_desc
    logic              hit;
    logic [ADDR_W-1:0] baseR;
    logic [IDX_W-1:0]  maskR, prodR, consR;

    assign hit = (curRingQ == RING_ID_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseR <= '0;
        maskR <= '0;
        prodR <= '0;
        consR <= '0;
      end else if (hit) begin
        if (strb.setBase) baseR <= curBaseQ;
        if (strb.ldMask)  maskR <= memRdata;
        if (strb.ldProd)       prodR <= memRdata;
        else if (strb.advProd) prodR <= prodNext;
        if (strb.ldCons)       consR <= memRdata;
        else if (strb.advCons) consR <= consNext;
      end
    end

    assign baseArr[g] = baseR;
    assign maskArr[g] = maskR;
    assign prodArr[g] = prodR;
    assign consArr[g] = consR;
  end

  always_comb begin
    selBase = '0;
    selMask = '0;
    selProd = '0;
    selCons = '0;
    for (int i = 0; i < NUM_RINGS; i++) begin
      if (curRingQ == RING_ID_W'(i)) begin
        selBase = baseArr[i];
        selMask = maskArr[i];
        selProd = prodArr[i];
        selCons = consArr[i];
      end
    end
  end

  assign prodNext   = (selProd + IDX_W'(1)) & selMask;
  assign consNext   = (selCons + IDX_W'(1)) & selMask;
  assign ringBad    = int'(curRingQ) >= NUM_RINGS;
  assign ringUnconf = (selBase == '0);
  assign remEmpty   = (remoteQ == selCons);
  assign remFull    = (prodNext == remoteQ);
  assign rdByte     = rdByteQ;

  always_comb begin
    case (strb.addrSel)
      AS_MASK:  memAddr = selBase - OFS_MASK;
      AS_PROD:  memAddr = selBase - OFS_PROD;
      AS_CONS:  memAddr = selBase - OFS_CONS;
      AS_PDATA: memAddr = selBase + ADDR_W'(selProd);
      AS_CDATA: memAddr = selBase + ADDR_W'(selCons);
      default:  memAddr = selBase;
    endcase
  end

  always_comb begin
    case (strb.wdSel)
      WS_PIDX: memWdata = selProd;
      WS_CIDX: memWdata = selCons;
      default: memWdata = curByteQ;
    endcase
  end

endmodule

// File: rtl/mem_ring_ctrl.sv
module mem_ring_ctrl
  import mem_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       busGnt,
  input  logic       memReady,
  input  logic       ringBad,
  input  logic       ringUnconf,
  input  logic       remEmpty,
  input  logic       remFull,
  output logic       reqReady,
  output logic       busReq,
  output logic       memValid,
  output logic       memWe,
  output logic       rspValid,
  output logic       rspFlag,
  output logic       rspErr,
  output dpStrobe_t  strb
);

  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_ACQ, S_ACC, S_REL, S_EVAL, S_RESP
  } state_e;

  state_e     stateQ, stateD;
  logic [2:0] opQ, opD;
  logic       phaseQ, phaseD;
  logic [1:0] stepQ, stepD;
  logic       flagQ, flagD, errQ, errD;

  // Micro-program for the access currently due
  addrSel_e pAddr;
  wdSel_e   pWd;
  logic     pWe, pLast;
  logic     pLdMask, pLdProd, pLdCons, pCapRem, pCapData, pAdvProd, pAdvCons;
  logic     fire, opLegal, blocked;

  always_comb begin
    pAddr = AS_MASK; pWd = WS_DATA; pWe = 1'b0; pLast = 1'b1;
    pLdMask = 1'b0; pLdProd = 1'b0; pLdCons = 1'b0; pCapRem = 1'b0;
    pCapData = 1'b0; pAdvProd = 1'b0; pAdvCons = 1'b0;
    case (opQ)
      OP_INIT: begin
        case (stepQ)
          2'd0:    begin pAddr = AS_MASK; pLdMask = 1'b1; pLast = 1'b0; end
          2'd1:    begin pAddr = AS_PROD; pLdProd = 1'b1; pLast = 1'b0; end
          default: begin pAddr = AS_CONS; pLdCons = 1'b1; end
        endcase
      end
      OP_EMPTY: begin pAddr = AS_PROD; pCapRem = 1'b1; end
      OP_FULL:  begin pAddr = AS_CONS; pCapRem = 1'b1; end
      OP_GET: begin
        if (!phaseQ) begin
          pAddr = AS_PROD; pCapRem = 1'b1;
        end else if (stepQ == 2'd0) begin
          pAddr = AS_CDATA; pCapData = 1'b1; pAdvCons = 1'b1; pLast = 1'b0;
        end else begin
          pAddr = AS_CONS; pWe = 1'b1; pWd = WS_CIDX;
        end
      end
      OP_PUT: begin
        if (!phaseQ) begin
          pAddr = AS_CONS; pCapRem = 1'b1;
        end else if (stepQ == 2'd0) begin
          pAddr = AS_PDATA; pWe = 1'b1; pWd = WS_DATA; pAdvProd = 1'b1; pLast = 1'b0;
        end else begin
          pAddr = AS_PROD; pWe = 1'b1; pWd = WS_PIDX;
        end
      end
      default: ;
    endcase
  end

  assign fire    = (stateQ == S_ACC) && memReady;
  assign opLegal = (opQ <= 3'd4);
  assign blocked = (opQ == OP_GET) ? remEmpty : remFull;

  always_comb begin
    strb           = '0;
    strb.latchReq  = (stateQ == S_IDLE) && reqValid;
    strb.setBase   = (stateQ == S_DECODE) && !ringBad && (opQ == OP_INIT);
    strb.ldMask    = fire && pLdMask;
    strb.ldProd    = fire && pLdProd;
    strb.ldCons    = fire && pLdCons;
    strb.capRemote = fire && pCapRem;
    strb.capData   = fire && pCapData;
    strb.advProd   = fire && pAdvProd;
    strb.advCons   = fire && pAdvCons;
    strb.addrSel   = pAddr;
    strb.wdSel     = pWd;
  end

  always_comb begin
    stateD = stateQ; opD = opQ; phaseD = phaseQ; stepD = stepQ;
    flagD = flagQ; errD = errQ;
    reqReady = 1'b0; busReq = 1'b0; memValid = 1'b0; rspValid = 1'b0;
    case (stateQ)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          opD = reqOp; phaseD = 1'b0; stepD = 2'd0;
          flagD = 1'b0; errD = 1'b0;
          stateD = S_DECODE;
        end
      end
      S_DECODE: begin
        if (ringBad || !opLegal) begin
          errD = 1'b1; stateD = S_RESP;
        end else if (ringUnconf && (opQ != OP_INIT)) begin
          if ((opQ == OP_EMPTY) || (opQ == OP_FULL)) flagD = 1'b1;
          else                                       errD  = 1'b1;
          stateD = S_RESP;
        end else begin
          stateD = S_ACQ;
        end
      end
      S_ACQ: begin
        busReq = 1'b1;
        if (busGnt) stateD = S_ACC;
      end
      S_ACC: begin
        busReq   = 1'b1;
        memValid = 1'b1;
        if (memReady) begin
          if (pLast) stateD = S_REL;
          else       stepD  = stepQ + 2'd1;
        end
      end
      S_REL: begin
        if (!busGnt) stateD = S_EVAL;
      end
      S_EVAL: begin
        stateD = S_RESP;
        stepD  = 2'd0;
        if (opQ == OP_EMPTY) begin
          flagD = remEmpty;
        end else if (opQ == OP_FULL) begin
          flagD = remFull;
        end else if (((opQ == OP_GET) || (opQ == OP_PUT)) && !phaseQ) begin
          stateD = S_ACQ;
          if (!blocked) phaseD = 1'b1;
        end
      end
      S_RESP: begin
        rspValid = 1'b1;
        stateD   = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      opQ    <= 3'd0;
      phaseQ <= 1'b0;
      stepQ  <= 2'd0;
      flagQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      opQ    <= opD;
      phaseQ <= phaseD;
      stepQ  <= stepD;
      flagQ  <= flagD;
      errQ   <= errD;
    end
  end

  assign memWe   = memValid && pWe;
  assign rspFlag = flagQ;
  assign rspErr  = errQ;

endmodule

// File: rtl/mem_ring_client.sv
module mem_ring_client
  import mem_ring_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int RING_ID_W = 3,
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [2:0]           reqOp,
  input  logic [RING_ID_W-1:0] reqRing,
  input  logic [ADDR_W-1:0]    reqBase,
  input  logic [IDX_W-1:0]     reqByte,
  output logic                 rspValid,
  output logic [IDX_W-1:0]     rspByte,
  output logic                 rspFlag,
  output logic                 rspErr,
  output logic                 busReq,
  input  logic                 busGnt,
  output logic                 memValid,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [IDX_W-1:0]     memWdata,
  input  logic                 memReady,
  input  logic [IDX_W-1:0]     memRdata
);

  dpStrobe_t strb;
  logic      ringBad, ringUnconf, remEmpty, remFull;

  mem_ring_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .busGnt     (busGnt),
    .memReady   (memReady),
    .ringBad    (ringBad),
    .ringUnconf (ringUnconf),
    .remEmpty   (remEmpty),
    .remFull    (remFull),
    .reqReady   (reqReady),
    .busReq     (busReq),
    .memValid   (memValid),
    .memWe      (memWe),
    .rspValid   (rspValid),
    .rspFlag    (rspFlag),
    .rspErr     (rspErr),
    .strb       (strb)
  );

  mem_ring_dpath #(
    .NUM_RINGS (NUM_RINGS),
    .RING_ID_W (RING_ID_W),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqRing    (reqRing),
    .reqBase    (reqBase),
    .reqByte    (reqByte),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .ringBad    (ringBad),
    .ringUnconf (ringUnconf),
    .remEmpty   (remEmpty),
    .remFull    (remFull),
    .rdByte     (rspByte)
  );

endmodule

// File: rtl/mem_ring_client_chk.sv
module mem_ring_client_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspErr,
  input logic              busReq,
  input logic              busGnt,
  input logic              memValid,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [IDX_W-1:0]  memWdata,
  input logic              memReady
);

  // R11: accesses only under a granted bus
  p_mem_granted_r11: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (busReq && busGnt));

  // R11: a pending access is held stable until completed
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R12: response is a single-cycle pulse
  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R12: busy after acceptance
  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R12: ready only while not using the bus
  p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busReq && !memValid));

  // R10: a rejected request ends with the bus fully released
  p_err_no_bus_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (!busReq && !busGnt));

endmodule

bind mem_ring_client mem_ring_client_chk #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .rspErr   (rspErr),
  .busReq   (busReq),
  .busGnt   (busGnt),
  .memValid (memValid),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memReady (memReady)
);

// File: tb/test_mem_ring_client.sv
`timescale 1ns/1ps
module test_mem_ring_client;

  localparam int NR = 3;
  localparam int RW = 2;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [2:0] C_INIT = 3'd0, C_EMPTY = 3'd1, C_FULL = 3'd2,
                         C_GET = 3'd3, C_PUT = 3'd4;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [2:0] reqOp = '0;
  logic [RW-1:0] reqRing = '0;
  logic [AW-1:0] reqBase = '0;
  logic [DW-1:0] reqByte = '0;
  logic rspValid, rspFlag, rspErr;
  logic [DW-1:0] rspByte;
  logic busReq, busGnt, memValid, memWe, memReady;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;

  always #10 clk = ~clk;

  mem_ring_client #(.NUM_RINGS(NR), .RING_ID_W(RW), .ADDR_W(AW), .IDX_W(DW)) i_mem_ring_client (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqRing(reqRing), .reqBase(reqBase), .reqByte(reqByte), .rspValid(rspValid),
    .rspByte(rspByte), .rspFlag(rspFlag), .rspErr(rspErr), .busReq(busReq),
    .busGnt(busGnt), .memValid(memValid), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata));

  // Peer memory, bus arbiter and peer-side writes
  logic [7:0] mem [256];
  logic peerWe = 1'b0;
  logic [7:0] peerAddr = '0, peerData = '0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReady <= 1'b0;
      memRdata <= '0;
      busGnt   <= 1'b0;
    end else begin
      busGnt <= busReq;
      if (peerWe) mem[peerAddr] <= peerData;
      if (memValid && !memReady) begin
        memReady <= 1'b1;
        if (memWe) mem[memAddr] <= memWdata;
        memRdata <= mem[memAddr];
      end else begin
        memReady <= 1'b0;
      end
    end
  end

  // Monitors
  int ownCnt = 0, rdCnt = 0, pollCnt = 0, cyc = 0;
  logic busReqD = 1'b0;
  always @(posedge clk) begin
    busReqD <= busReq;
    if (busReq && !busReqD) ownCnt <= ownCnt + 1;
    if (memValid && memReady && !memWe) begin
      rdCnt <= rdCnt + 1;
      if (memAddr == 8'h1E) pollCnt <= pollCnt + 1;
    end
  end

  int checks = 0, failures = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] rByte;
  logic rFlag, rErr;
  int ownDelta, rdDelta;

  task automatic doReq(input logic [2:0] op, input logic [RW-1:0] ring,
                       input logic [7:0] base, input logic [7:0] data);
    int own0, rd0;
    own0 = ownCnt; rd0 = rdCnt;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqRing = ring; reqBase = base; reqByte = data;
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
    rByte = rspByte; rFlag = rspFlag; rErr = rspErr;
    ownDelta = ownCnt - own0;
    rdDelta  = rdCnt - rd0;
  endtask

  task automatic peerWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    peerWe = 1'b1; peerAddr = a; peerData = d;
    @(negedge clk);
    peerWe = 1'b0;
  endtask

  logic [7:0] p0, c0, v;
  logic done;
  int poll0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reqReady", reqReady, 1);
    chk("R1 busReq", busReq, 0);
    chk("R1 memValid", memValid, 0);
    chk("R1 rspValid", rspValid, 0);

    // R6 unconfigured ring 2
    doReq(C_EMPTY, 2, 0, 0);
    chk("R6 empty flag", rFlag, 1); chk("R6 empty no bus", ownDelta, 0);
    @(negedge clk);
    chk("R12 pulse one cycle", rspValid, 0);
    doReq(C_FULL, 2, 0, 0);
    chk("R6 full flag", rFlag, 1); chk("R6 full no bus", ownDelta, 0);
    doReq(C_GET, 2, 0, 0);
    chk("R6 get err", rErr, 1); chk("R6 get no bus", ownDelta, 0);
    doReq(C_PUT, 2, 0, 8'h55);
    chk("R6 put err", rErr, 1);

    // R10 bad ring / bad op
    doReq(C_EMPTY, 3, 0, 0);
    chk("R10 ring range err", rErr, 1); chk("R10 no bus", ownDelta, 0);
    doReq(3'd5, 0, 0, 0);
    chk("R10 op code err", rErr, 1);

    // R3 init ring 0 at base 0x20: mask 7, prod 5, cons 5
    peerWrite(8'h1D, 8'h07); peerWrite(8'h1E, 8'h05); peerWrite(8'h1F, 8'h05);
    doReq(C_INIT, 0, 8'h20, 0);
    chk("R3 init ok", rErr, 0); chk("R3 one ownership", ownDelta, 1);
    chk("R3 three reads", rdDelta, 3);
    p0 = 8'h05; c0 = 8'h05;
    doReq(C_EMPTY, 0, 0, 0); chk("R4 empty after init", rFlag, 1);
    doReq(C_FULL, 0, 0, 0);  chk("R5 full after init", rFlag, 0);

    // Fill/drain sweep with wrap (R2, R7, R8, R9)
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 7; k++) begin
        v = 8'(8'h31 * k + 8'h07 * r + 1);
        doReq(C_PUT, 0, 0, v);
        chk("R8 put data at base+prod", mem[8'(8'h20 + p0)], v);
        p0 = (p0 + 8'd1) & 8'h07;
        chk("R8 prod index at base-2", mem[8'h1E], p0);
        chk("R9 put two ownerships", ownDelta, 2);
      end
      doReq(C_FULL, 0, 0, 0);  chk("R5 full when filled", rFlag, 1);
      doReq(C_EMPTY, 0, 0, 0); chk("R4 not empty when filled", rFlag, 0);
      for (int k = 0; k < 7; k++) begin
        v = 8'(8'h31 * k + 8'h07 * r + 1);
        doReq(C_GET, 0, 0, 0);
        chk("R7 get data", rByte, v);
        c0 = (c0 + 8'd1) & 8'h07;
        chk("R7 cons index at base-1", mem[8'h1F], c0);
        chk("R9 get two ownerships", ownDelta, 2);
      end
      doReq(C_EMPTY, 0, 0, 0); chk("R4 empty when drained", rFlag, 1);
      doReq(C_FULL, 0, 0, 0);  chk("R5 not full when drained", rFlag, 0);
    end

    // R7 blocking get: peer produces later
    done = 1'b0; poll0 = pollCnt;
    fork
      begin doReq(C_GET, 0, 0, 0); done = 1'b1; end
      begin
        repeat (40) @(negedge clk);
        chk("R7 get blocked while empty", done, 0);
        peerWrite(8'(8'h20 + p0), 8'h5A);
        peerWrite(8'h1E, (p0 + 8'd1) & 8'h07);
      end
    join
    chk("R7 blocked get data", rByte, 8'h5A);
    c0 = (c0 + 8'd1) & 8'h07;
    chk("R7 blocked get cons", mem[8'h1F], c0);
    chk("R9 repeated polls", (pollCnt - poll0) >= 2, 1);
    doReq(C_INIT, 0, 8'h20, 0);
    p0 = c0;

    // R8 blocking put: peer consumes later
    for (int k = 0; k < 7; k++) begin
      doReq(C_PUT, 0, 0, 8'(8'h80 + k));
      p0 = (p0 + 8'd1) & 8'h07;
    end
    done = 1'b0;
    fork
      begin doReq(C_PUT, 0, 0, 8'hE7); done = 1'b1; end
      begin
        repeat (40) @(negedge clk);
        chk("R8 put blocked while full", done, 0);
        peerWrite(8'h1F, (c0 + 8'd1) & 8'h07);
      end
    join
    chk("R8 blocked put data", mem[8'(8'h20 + p0)], 8'hE7);
    p0 = (p0 + 8'd1) & 8'h07;
    chk("R8 blocked put prod", mem[8'h1E], p0);
    doReq(C_INIT, 0, 8'h20, 0);
    doReq(C_FULL, 0, 0, 0); chk("R5 full after reinit", rFlag, 1);

    // R2/R13 ring 1 at base 0x01: header wraps below address 0
    peerWrite(8'hFE, 8'h03); peerWrite(8'hFF, 8'h02); peerWrite(8'h00, 8'h02);
    doReq(C_INIT, 1, 8'h01, 0);
    doReq(C_PUT, 1, 0, 8'hAB);
    chk("R2 ring1 data addr", mem[8'h03], 8'hAB);
    chk("R2 ring1 prod addr wrap", mem[8'hFF], 8'h03);
    doReq(C_PUT, 1, 0, 8'hCD);
    chk("R2 ring1 second data", mem[8'h04], 8'hCD);
    chk("R2 ring1 prod masked", mem[8'hFF], 8'h00);
    doReq(C_GET, 1, 0, 0);
    chk("R2 ring1 get data", rByte, 8'hAB);
    chk("R2 ring1 cons addr", mem[8'h00], 8'h03);
    doReq(C_FULL, 0, 0, 0);
    chk("R13 ring0 still full", rFlag, 1);
    chk("R13 ring0 prod header", mem[8'h1E], p0);
    @(negedge clk);
    chk("R12 ready after response", reqReady, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule